// File: doc/BRIEF.md
# RTC interrupt status and request logic

This block keeps the interrupt status of a real-time clock and drives its active-low interrupt request pin. Three event sources feed it. The update engine sends a pulse when an update cycle ends. The alarm comparator sends a pulse when the time matches the alarm. A divider tick steps an internal binary divider, and a 4-bit rate select picks which divider stage produces a periodic event. Each source sets its own sticky flag whatever its enable says. The master request bit and the pin follow the flags that have their enable set.

Software reads the status byte over a plain parallel read port. The read returns the flag values from before that cycle, and the same cycle clears every flag. An event that lands in the clearing cycle is kept. A second address returns a battery-valid byte, which comes straight from the battery monitor input. Reset does not touch it. All pins are plain control and status wires. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure.

Top module: `rtc_irq_status`

## Requirements
- R1: At `rd_addr`=0, `rd_data` holds the status byte. Bit 7 is the master request, bit 6 the periodic flag, bit 5 the alarm flag and bit 4 the update flag. Bits 3..0 are always 0.
- R2: A pulse on `upd_pulse` or `alarm_pulse`, or a periodic event, sets its flag at that clock edge whatever the enables are. The flag then stays set until it is cleared.
- R3: The master bit is 1 exactly when at least one of these pairs holds: periodic flag and `per_en`, alarm flag and `alarm_en`, update flag and `upd_en`.
- R4: `irq_n` is registered. It equals the inverse of the master bit one cycle earlier, so it goes low one cycle after the master bit sets and high one cycle after it clears.
- R5: A cycle with `rd_stb`=1 and `rd_addr`=0 returns the pre-clear status on `rd_data` and clears all three flags at the end of that cycle. A read with `rd_addr`=1 clears nothing.
- R6: An event that arrives in the same cycle as a clearing read leaves its flag set after that edge.
- R7: With `rate_sel`=0 no periodic event occurs. For `rate_sel`=r (1..15), counting divider ticks from reset, the periodic event fires on tick 2^(r-1) and then every 2^r ticks.
- R8: At `rd_addr`=1, `rd_data` is {`batt_ok`, 7'b0}, and it holds that value while reset is asserted.
- R9: While `rst_n` is low, all flags and the divider are 0 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_pulse | input | 1 | One-cycle pulse at the end of an update cycle |
| alarm_pulse | input | 1 | One-cycle pulse when the time matches the alarm |
| div_tick | input | 1 | Divider-chain step, one per cycle when high |
| upd_en | input | 1 | Update interrupt enable |
| alarm_en | input | 1 | Alarm interrupt enable |
| per_en | input | 1 | Periodic interrupt enable |
| rate_sel | input | RATE_W | Periodic rate select, 0 = off |
| rd_stb | input | 1 | Read strobe |
| rd_addr | input | 1 | 0 = status byte, 1 = battery byte |
| batt_ok | input | 1 | Battery-valid level from the monitor |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| irq_n | output | 1 | Registered active-low interrupt request |

## Verification
A flag that is stuck or lost shows on `rd_data` in the same cycle, because the read path is combinational. It shows on `irq_n` one cycle later. A divider count that is off, or a wrong tap decode, shows only as the periodic flag rising on the wrong tick. That can take up to 2^14 ticks at the slowest rate, so the first-event tick is checked at the fastest, a middle and the slowest rate. A clear that comes too early, too late or not at all shows on the very next status read, and also on whether an event in the clearing cycle survives.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int NUM_EV   = 3;
  localparam int EV_UPD   = 0;
  localparam int EV_ALM   = 1;
  localparam int EV_PER   = 2;
  localparam int BIT_MSTR = 7;
  localparam int BIT_PER  = 6;
  localparam int BIT_ALM  = 5;
  localparam int BIT_UPD  = 4;
  localparam logic SEL_STATUS = 1'b0;
  localparam logic SEL_BATT   = 1'b1;
endpackage

// File: rtl/rtc_rate_tap.sv
module rtc_rate_tap #(
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [RATE_W-1:0] rate_sel,
  output logic              per_evt
);
  localparam int DIV_W  = (2 ** RATE_W) - 1;
  localparam int SEL_N  = 2 ** RATE_W;

  logic [DIV_W-1:0] div_q;
  logic [SEL_N-1:0] stage_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else if (tick) div_q <= div_q + {{(DIV_W-1){1'b0}}, 1'b1};
  end

  // stage k rises when the lower bits are all ones and bit k is zero
  assign stage_rise[0] = 1'b0;
  for (genvar k = 0; k < DIV_W; k++) begin : g_stage
    if (k == 0) begin : g_lsb
      assign stage_rise[1] = tick & ~div_q[0];
    end else begin : g_upper
      assign stage_rise[k+1] = tick & (&div_q[k-1:0]) & ~div_q[k];
    end
  end

  assign per_evt = stage_rise[rate_sel];
endmodule

// File: rtl/rtc_event_flag.sv
module rtc_event_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // a set in the clearing cycle wins, so no event is lost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= set_i | (flag_o & ~clr_i);
  end
endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status
  import rtc_irq_pkg::*;
#(
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_pulse,
  input  logic              alarm_pulse,
  input  logic              div_tick,
  input  logic              upd_en,
  input  logic              alarm_en,
  input  logic              per_en,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              rd_stb,
  input  logic              rd_addr,
  input  logic              batt_ok,
  output logic [7:0]        rd_data,
  output logic              irq_n
);
  logic              per_evt;
  logic [NUM_EV-1:0] ev_set;
  logic [NUM_EV-1:0] ev_en;
  logic [NUM_EV-1:0] flags;
  logic              rd_clr;
  logic              master;
  logic [7:0]        status_byte;
  logic [7:0]        batt_byte;

  rtc_rate_tap #(.RATE_W(RATE_W)) u_tap (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (div_tick),
    .rate_sel (rate_sel),
    .per_evt  (per_evt)
  );

  always_comb begin
    ev_set         = '0;
    ev_set[EV_UPD] = upd_pulse;
    ev_set[EV_ALM] = alarm_pulse;
    ev_set[EV_PER] = per_evt;
    ev_en          = '0;
    ev_en[EV_UPD]  = upd_en;
    ev_en[EV_ALM]  = alarm_en;
    ev_en[EV_PER]  = per_en;
  end

  assign rd_clr = rd_stb & (rd_addr == SEL_STATUS);

  for (genvar i = 0; i < NUM_EV; i++) begin : g_flag
    rtc_event_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (ev_set[i]),
      .clr_i  (rd_clr),
      .flag_o (flags[i])
    );
  end

  assign master = |(flags & ev_en);

  always_comb begin
    status_byte           = '0;
    status_byte[BIT_MSTR] = master;
    status_byte[BIT_PER]  = flags[EV_PER];
    status_byte[BIT_ALM]  = flags[EV_ALM];
    status_byte[BIT_UPD]  = flags[EV_UPD];
    batt_byte             = '0;
    batt_byte[7]          = batt_ok;
  end

  assign rd_data = (rd_addr == SEL_BATT) ? batt_byte : status_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n <= 1'b1;
    else        irq_n <= ~master;
  end
endmodule

// File: rtl/rtc_irq_status_chk.sv
module rtc_irq_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       upd_pulse,
  input logic       alarm_pulse,
  input logic       upd_en,
  input logic [3:0] rate_sel,
  input logic       rd_stb,
  input logic       rd_addr,
  input logic       batt_ok,
  input logic [7:0] status,
  input logic [7:0] rd_data,
  input logic       irq_n
);
  logic clr;
  assign clr = rd_stb & ~rd_addr;

  assert_low_nibble_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_addr |-> rd_data[3:0] == 4'b0);

  assert_per_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status[6] && !clr |=> status[6]);

  assert_alm_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status[5] && !clr |=> status[5]);

  assert_alm_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |=> status[5]);

  assert_master_needs_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    status[7] |-> (|status[6:4]));

  assert_upd_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    status[4] && upd_en |-> status[7]);

  assert_irq_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_n == !$past(status[7]));

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !upd_pulse |=> !status[4]);

  assert_event_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |=> status[4]);

  assert_rate_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rate_sel == 4'd0 && !status[6] && !rd_stb |=> !status[6]);

  assert_batt_byte_R8: assert property (@(posedge clk)
    rd_addr |-> rd_data[6:0] == 7'b0 && rd_data[7] == batt_ok);

  assert_reset_irq_R9: assert property (@(posedge clk)
    !rst_n |=> irq_n);
endmodule

bind rtc_irq_status rtc_irq_status_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .upd_pulse   (upd_pulse),
  .alarm_pulse (alarm_pulse),
  .upd_en      (upd_en),
  .rate_sel    (rate_sel[3:0]),
  .rd_stb      (rd_stb),
  .rd_addr     (rd_addr),
  .batt_ok     (batt_ok),
  .status      (status_byte),
  .rd_data     (rd_data),
  .irq_n       (irq_n)
);

// File: tb/rtc_irq_status_test.sv
module rtc_irq_status_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       upd_pulse = 1'b0, alarm_pulse = 1'b0, div_tick = 1'b0;
  logic       upd_en = 1'b0, alarm_en = 1'b0, per_en = 1'b0;
  logic [3:0] rate_sel = 4'd0;
  logic       rd_stb = 1'b0, rd_addr = 1'b0, batt_ok = 1'b1;
  logic [7:0] rd_data;
  logic       irq_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rtc_irq_status uut (
    .clk(clk), .rst_n(rst_n), .upd_pulse(upd_pulse), .alarm_pulse(alarm_pulse),
    .div_tick(div_tick), .upd_en(upd_en), .alarm_en(alarm_en), .per_en(per_en),
    .rate_sel(rate_sel), .rd_stb(rd_stb), .rd_addr(rd_addr), .batt_ok(batt_ok),
    .rd_data(rd_data), .irq_n(irq_n)
  );

  // en = {per, alarm, update}, ev = {alarm pulse, update pulse}
  typedef struct packed {
    logic [2:0] en;
    logic [1:0] ev;
    logic [7:0] exp;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{3'b000, 2'b01, 8'h10}, '{3'b001, 2'b01, 8'h90},
    '{3'b000, 2'b10, 8'h20}, '{3'b010, 2'b10, 8'hA0},
    '{3'b010, 2'b01, 8'h10}, '{3'b011, 2'b11, 8'hB0},
    '{3'b000, 2'b11, 8'h30}, '{3'b100, 2'b11, 8'h30},
    '{3'b001, 2'b00, 8'h00}, '{3'b110, 2'b01, 8'h10}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic ticks(input int n);
    if (n == 0) return;
    div_tick = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk); div_tick = 1'b0;
  endtask

  task automatic clear_read();
    rd_addr = 1'b0; rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
  endtask

  task automatic first_event(input int r);
    int first;
    first = 1 << (r - 1);
    do_reset();
    rate_sel = 4'(r);
    ticks(first - 1);
    #1 chk($sformatf("R7 rate %0d before tick %0d", r, first), {7'b0, rd_data[6]}, 8'h00);
    ticks(1);
    #1 chk($sformatf("R7 rate %0d at tick %0d", r, first), {7'b0, rd_data[6]}, 8'h01);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // reset state, battery byte during reset (R8, R9)
    repeat (2) @(negedge clk);
    rd_addr = 1'b1; #1 chk("R8 batt during reset", rd_data, 8'h80);
    batt_ok = 1'b0; #1 chk("R8 batt low during reset", rd_data, 8'h00);
    batt_ok = 1'b1;
    rd_addr = 1'b0; #1 chk("R9 status in reset", rd_data, 8'h00);
    chk("R9 irq_n in reset", {7'b0, irq_n}, 8'h01);
    @(negedge clk); rst_n = 1'b1;

    // vector table (R1..R5)
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      {per_en, alarm_en, upd_en} = VECS[i].en;
      {alarm_pulse, upd_pulse}   = VECS[i].ev;
      @(negedge clk);
      upd_pulse = 1'b0; alarm_pulse = 1'b0;
      chk($sformatf("R4 vec %0d irq_n not yet", i), {7'b0, irq_n}, 8'h01);
      @(negedge clk);
      chk($sformatf("R4 vec %0d irq_n", i), {7'b0, irq_n}, {7'b0, ~VECS[i].exp[7]});
      rd_addr = 1'b0; rd_stb = 1'b1;
      #1 chk($sformatf("R1 R2 R3 vec %0d status", i), rd_data, VECS[i].exp);
      @(negedge clk); rd_stb = 1'b0;
      #1 chk($sformatf("R5 vec %0d after clear", i), rd_data, 8'h00);
      @(negedge clk);
      chk($sformatf("R4 vec %0d irq_n released", i), {7'b0, irq_n}, 8'h01);
    end

    // battery read does not clear (R5)
    {per_en, alarm_en, upd_en} = 3'b000;
    upd_pulse = 1'b1; @(negedge clk); upd_pulse = 1'b0;
    rd_addr = 1'b1; rd_stb = 1'b1; @(negedge clk); rd_stb = 1'b0;
    rd_addr = 1'b0; #1 chk("R5 battery read keeps flags", rd_data, 8'h10);

    // event in clearing cycle survives (R6)
    rd_stb = 1'b1; upd_pulse = 1'b1;
    #1 chk("R6 read value pre-clear", rd_data, 8'h10);
    @(negedge clk); rd_stb = 1'b0; upd_pulse = 1'b0;
    #1 chk("R6 update kept", rd_data, 8'h10);
    rd_stb = 1'b1; alarm_pulse = 1'b1;
    @(negedge clk); rd_stb = 1'b0; alarm_pulse = 1'b0;
    #1 chk("R6 alarm kept, update cleared", rd_data, 8'h20);

    // reset clears flags (R9)
    alarm_en = 1'b1;
    @(negedge clk);
    chk("R4 alarm irq_n low", {7'b0, irq_n}, 8'h00);
    rst_n = 1'b0; #1;
    chk("R9 reset clears status", rd_data, 8'h00);
    chk("R9 reset raises irq_n", {7'b0, irq_n}, 8'h01);
    @(negedge clk); rst_n = 1'b1; alarm_en = 1'b0;

    // periodic rate select (R7)
    rate_sel = 4'd0;
    ticks(64);
    #1 chk("R7 rate 0 no event", {7'b0, rd_data[6]}, 8'h00);
    first_event(1);
    first_event(5);
    first_event(3);
    per_en = 1'b1;
    clear_read();
    ticks(7);
    #1 chk("R7 rate 3 no event before tick 12", {7'b0, rd_data[6]}, 8'h00);
    ticks(1);
    #1 chk("R7 rate 3 event at tick 12", rd_data, 8'hC0);
    @(negedge clk);
    chk("R4 periodic irq_n low", {7'b0, irq_n}, 8'h00);
    per_en = 1'b0;
    first_event(15);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule